// File: doc/BRIEF.md
# Half-Word Paired Scratch RAM Bridge

This block connects a processor register bus to a 512 x 32-bit scratch RAM that belongs to an accelerator engine. The bus may write 16 bits at a time. A write to the lower half of a word only fills a 16-bit holding register. A write to the upper half commits one full 32-bit word, made of the new upper half and the held lower half. The holding register keeps its value after a commit, so software can initialise many words that share a lower half with one upper-half write per word. A single-byte write takes a different path: the bridge reads the target word, merges the byte into it and writes it back, without using the holding register.

Reads go through a registered read path and take several cycles. The requester raises `bus_req` for one cycle and then waits for the one-cycle `bus_done` pulse. While the engine reports itself busy, every request is still completed on the bus, but the RAM is not touched. The RAM contents are never cleared by reset. Only the holding register is.

The controller is a single state machine with six states:
- `S_IDLE` waits for a request.
- `S_RD` issues a RAM read.
- `S_WAIT` captures the RAM output.
- `S_MERGE` inserts the new byte.
- `S_WRITE` drives the RAM write.
- `S_DONE` raises `bus_done`.

Its transitions are:
- From `S_IDLE`, an accepted request goes to one of three states:
  - `S_DONE` for a lower-half load or any request made while the engine is busy.
  - `S_WRITE` for an upper-half commit.
  - `S_RD` for a read or a byte write.
- `S_RD` always goes to `S_WAIT`.
- `S_WAIT` goes to `S_DONE` for a read and to `S_MERGE` for a byte write.
- `S_MERGE` goes to `S_WRITE`.
- `S_WRITE` goes to `S_DONE`.
- `S_DONE` goes back to `S_IDLE`.

Top module: `hwbuf_ram_bridge`

## Requirements
- R1: The word index is `bus_addr[10:2]`. Byte lane i of a word is bits [8i+7:8i] of `bus_wdata`, `bus_rdata` and the RAM data, and is selected by `bus_be[i]`.
- R2: A request accepted while `engine_busy` is 1 has no RAM read or write and leaves the holding register unchanged. It completes with `bus_done` one cycle after acceptance, and `bus_rdata` is 0 during that pulse.
- R3: After reset the holding register is zero, so an upper-half write with no preceding lower-half load stores zero in bits [15:0].
- R4: A write with `bus_be`=4'b0011 loads `bus_wdata[15:0]` into the holding register. It causes no RAM access and completes one cycle after acceptance.
- R5: A write whose byte enables are neither 4'b0011 nor a single lane performs exactly one RAM write of {`bus_wdata[31:16]`, holding register}. `ram_we` is high in the cycle after acceptance and `bus_done` follows one cycle later.
- R6: A commit does not consume the holding register. Later upper-half writes to other words reuse the same lower half.
- R7: A write with exactly one byte enable set reads the target word once and writes it back once with only that lane replaced. It leaves the holding register unchanged and completes five cycles after acceptance.
- R8: A read (`bus_we`=0) performs one RAM read. It completes three cycles after acceptance, with the word on `bus_rdata` during the `bus_done` cycle.
- R9: `bus_done` is a single-cycle pulse and is low after reset. A request presented while an earlier operation is still running is ignored and has no effect.
- R10: `ram_we` and `ram_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | One-cycle request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data, lane aligned |
| bus_rdata | output | 32 | Read data, valid with bus_done |
| bus_done | output | 1 | Completion pulse |
| engine_busy | input | 1 | Engine owns the RAM; accesses are dropped |
| ram_addr | output | 9 | RAM word address |
| ram_re | output | 1 | RAM read enable (data one cycle later) |
| ram_rdata | input | 32 | RAM read data |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 32 | RAM write data |

## Verification
The assertions assume that the RAM returns read data exactly one cycle after `ram_re`. They also assume that the requester raises `bus_req` only as a single-cycle strobe, and that the byte enables of a write are non-zero. The bench keeps within these assumptions in three ways:
- Its RAM model registers `ram_rdata` on the edge that samples `ram_re`.
- Every request is driven for one cycle between falling edges, and the next one is issued only after `bus_done`, except in the deliberate overlap test.
- Only non-zero enable patterns (low half, high half, full word and single lanes) are applied.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

    typedef enum logic [1:0] {
        K_LOW  = 2'd0,
        K_HIGH = 2'd1,
        K_BYTE = 2'd2,
        K_READ = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RD    = 3'd1,
        S_WAIT  = 3'd2,
        S_MERGE = 3'd3,
        S_WRITE = 3'd4,
        S_DONE  = 3'd5
    } state_e;

endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
    import hwb_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             we,
    input  logic [LANES-1:0] be,
    output kind_e            kind
);
    localparam int HALF_L = LANES / 2;
    localparam logic [LANES-1:0] LOW_PAT = {{(LANES-HALF_L){1'b0}}, {HALF_L{1'b1}}};

    always_comb begin
        if (!we)
            kind = K_READ;
        else if (be == LOW_PAT)
            kind = K_LOW;
        else if ($onehot(be))
            kind = K_BYTE;
        else
            kind = K_HIGH;
    end
endmodule

// File: rtl/hwb_lowbuf.sv
module hwb_lowbuf #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] din,
    output logic [HALF_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/hwb_merge.sv
module hwb_merge #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] old_word,
    input  logic [LANES*8-1:0] new_word,
    input  logic [LANES-1:0]   lane_sel,
    output logic [LANES*8-1:0] merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*8 +: 8] = lane_sel[i] ? new_word[i*8 +: 8] : old_word[i*8 +: 8];
    end
endmodule

// File: rtl/hwb_ctrl.sv
module hwb_ctrl
    import hwb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   busy,
    input  kind_e  kind_in,
    input  kind_e  kind_q,
    output state_e state,
    output logic   accept,
    output logic   rd_en,
    output logic   wr_en,
    output logic   done
);
    state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req) begin
                    if (busy)
                        nxt = S_DONE;
                    else begin
                        unique case (kind_in)
                            K_LOW:  nxt = S_DONE;
                            K_HIGH: nxt = S_WRITE;
                            K_BYTE: nxt = S_RD;
                            K_READ: nxt = S_RD;
                        endcase
                    end
                end
            end
            S_RD:    nxt = S_WAIT;
            S_WAIT:  nxt = (kind_q == K_READ) ? S_DONE : S_MERGE;
            S_MERGE: nxt = S_WRITE;
            S_WRITE: nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        accept = (state == S_IDLE) && req;
        rd_en  = (state == S_RD);
        wr_en  = (state == S_WRITE);
        done   = (state == S_DONE);
    end
endmodule

// File: rtl/hwbuf_ram_bridge.sv
module hwbuf_ram_bridge
    import hwb_pkg::*;
#(
    parameter int WORD_AW = 9,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [WORD_AW+1:0]        bus_addr,
    input  logic [DATA_W/8-1:0]       bus_be,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      bus_done,
    input  logic                      engine_busy,
    output logic [WORD_AW-1:0]        ram_addr,
    output logic                      ram_re,
    input  logic [DATA_W-1:0]         ram_rdata,
    output logic                      ram_we,
    output logic [DATA_W-1:0]         ram_wdata
);
    localparam int LANES  = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;

    kind_e               kind_in;
    kind_e               kind_q;
    state_e              state;
    logic                accept;
    logic                rd_en;
    logic                wr_en;
    logic                done;
    logic [HALF_W-1:0]   buf_q;
    logic [WORD_AW-1:0]  addr_q;
    logic [LANES-1:0]    be_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   word_q;
    logic [DATA_W-1:0]   rd_q;
    logic [DATA_W-1:0]   merged;
    logic                buf_load;

    hwb_decode #(.LANES(LANES)) u_dec (
        .we   (bus_we),
        .be   (bus_be),
        .kind (kind_in)
    );

    hwb_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .busy    (engine_busy),
        .kind_in (kind_in),
        .kind_q  (kind_q),
        .state   (state),
        .accept  (accept),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .done    (done)
    );

    assign buf_load = accept && !engine_busy && (kind_in == K_LOW);

    hwb_lowbuf #(.HALF_W(HALF_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (buf_load),
        .din   (bus_wdata[HALF_W-1:0]),
        .dout  (buf_q)
    );

    hwb_merge #(.LANES(LANES)) u_merge (
        .old_word (word_q),
        .new_word (wdata_q),
        .lane_sel (be_q),
        .merged   (merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_READ;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            word_q  <= '0;
            rd_q    <= '0;
        end else begin
            if (accept) begin
                kind_q  <= kind_in;
                addr_q  <= bus_addr[WORD_AW+1:2];
                be_q    <= bus_be;
                wdata_q <= bus_wdata;
                rd_q    <= '0;
            end
            if (state == S_WAIT) begin
                if (kind_q == K_READ)
                    rd_q <= ram_rdata;
                else
                    word_q <= ram_rdata;
            end
            if (state == S_MERGE)
                word_q <= merged;
        end
    end

    always_comb begin
        ram_addr  = addr_q;
        ram_re    = rd_en;
        ram_we    = wr_en;
        ram_wdata = (kind_q == K_HIGH) ? {wdata_q[DATA_W-1:HALF_W], buf_q} : word_q;
        bus_done  = done;
        bus_rdata = done ? rd_q : '0;
    end
endmodule

// File: rtl/hwb_checker.sv
module hwb_checker
    import hwb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic              engine_busy,
    input kind_e             kind_in,
    input kind_e             kind_q,
    input logic              ram_we,
    input logic              ram_re,
    input logic              bus_done,
    input logic [DATA_W-1:0] ram_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W/2-1:0] buf_q
);
    p_bypass_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && engine_busy |=> bus_done && !ram_we && !ram_re && (bus_rdata == '0));

    p_low_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !engine_busy && kind_in == K_LOW |=> bus_done && !ram_we && !ram_re);

    p_commit_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !engine_busy && kind_in == K_HIGH |=> ram_we ##1 (bus_done && !ram_we));

    p_commit_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && kind_q == K_HIGH |-> ram_wdata[DATA_W/2-1:0] == buf_q);

    p_buf_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && !engine_busy && kind_in == K_LOW) |=> $stable(buf_q));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |=> !bus_done);

    p_ram_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));
endmodule

bind hwbuf_ram_bridge hwb_checker #(.DATA_W(DATA_W)) u_hwb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .engine_busy (engine_busy),
    .kind_in     (kind_in),
    .kind_q      (kind_q),
    .ram_we      (ram_we),
    .ram_re      (ram_re),
    .bus_done    (bus_done),
    .ram_wdata   (ram_wdata),
    .bus_rdata   (bus_rdata),
    .buf_q       (buf_q)
);

// File: tb/test_hwbuf_ram_bridge.sv
module test_hwbuf_ram_bridge;
    localparam int PERIOD = 10;
    localparam int NW     = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_done;
    logic        engine_busy = 1'b0;
    logic [8:0]  ram_addr;
    logic        ram_re;
    logic [31:0] ram_rdata;
    logic        ram_we;
    logic [31:0] ram_wdata;

    logic [31:0] mem [NW];
    logic [31:0] refm [NW];
    logic [15:0] refbuf;
    int n_we = 0;
    int n_re = 0;
    int errors = 0;
    int checks = 0;

    always #(PERIOD/2) clk = ~clk;

    hwbuf_ram_bridge i_hwbuf_ram_bridge (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_done(bus_done), .engine_busy(engine_busy),
        .ram_addr(ram_addr), .ram_re(ram_re), .ram_rdata(ram_rdata),
        .ram_we(ram_we), .ram_wdata(ram_wdata)
    );

    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            n_we <= n_we + 1;
        end
        if (ram_re) begin
            ram_rdata <= mem[ram_addr];
            n_re <= n_re + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // issue one request, wait for done, check latency and RAM traffic
    task automatic op(input bit we, input int word, input logic [1:0] off, input logic [3:0] be,
                      input logic [31:0] wd, input int exp_lat, input int exp_w, input int exp_r,
                      input string req, output logic [31:0] rd);
        int lat = 1;
        int w0;
        int r0;
        @(negedge clk);
        w0 = n_we;
        r0 = n_re;
        bus_req = 1'b1; bus_we = we; bus_addr = {word[8:0], off}; bus_be = be; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        while (!bus_done) begin
            @(negedge clk);
            lat++;
            if (lat > 40) begin
                chk(1'b0, {req, " watchdog"}, 32'(lat), 32'(exp_lat));
                summary();
            end
        end
        rd = bus_rdata;
        chk(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
        @(negedge clk);
        chk(!bus_done, "R9 done pulse", 32'(bus_done), 32'd0);
        chk(n_we - w0 == exp_w && n_re - r0 == exp_r, {req, " R10 ram ops"},
            32'((n_we - w0) * 16 + (n_re - r0)), 32'(exp_w * 16 + exp_r));
    endtask

    function automatic logic [15:0] hi_pat(int w);
        return 16'(w * 16'h02F1 + 16'h1357);
    endfunction
    function automatic logic [15:0] lo_pat(int w);
        return 16'(w) ^ 16'hA5C3;
    endfunction

    initial begin
        #(PERIOD * 190000);
        chk(1'b0, "global watchdog", 32'd0, 32'd1);
        summary();
    end

    initial begin
        logic [31:0] rd;
        refbuf = 16'h0000;
        repeat (3) @(negedge clk);
        chk(bus_done == 1'b0 && ram_we == 1'b0 && ram_re == 1'b0, "R9 reset outputs",
            {29'd0, bus_done, ram_we, ram_re}, 32'd0);
        rst_n = 1'b1;

        // R3: buffer is zero after reset
        op(1'b1, 7, 2'd2, 4'b1100, 32'hBEEF_0000, 2, 1, 0, "R3 commit", rd);
        op(1'b0, 7, 2'd0, 4'b1111, 32'd0, 3, 0, 1, "R8 read", rd);
        chk(rd == 32'hBEEF_0000, "R3 zero low half", rd, 32'hBEEF_0000);

        // R4/R5 sweep over every word
        for (int w = 0; w < NW; w++) begin
            op(1'b1, w, 2'd0, 4'b0011, {16'hDEAD, lo_pat(w)}, 1, 0, 0, "R4 low load", rd);
            op(1'b1, w, 2'd2, (w % 2 == 0) ? 4'b1100 : 4'b1111, {hi_pat(w), 16'h5555}, 2, 1, 0, "R5 commit", rd);
            refm[w] = {hi_pat(w), lo_pat(w)};
        end
        refbuf = lo_pat(NW - 1);
        // R8/R1 read back, address offset bits ignored
        for (int w = 0; w < NW; w++) begin
            op(1'b0, w, 2'(w % 4), 4'b1111, 32'd0, 3, 0, 1, "R8 read", rd);
            chk(rd == refm[w], "R1 R5 R8 readback", rd, refm[w]);
        end

        // R6: buffer reused across commits
        op(1'b1, 0, 2'd0, 4'b0011, 32'h0000_3C3C, 1, 0, 0, "R4 low load", rd);
        refbuf = 16'h3C3C;
        for (int w = 100; w < 108; w++) begin
            op(1'b1, w, 2'd2, 4'b1100, {16'(w), 16'hFFFF}, 2, 1, 0, "R6 commit", rd);
            refm[w] = {16'(w), refbuf};
        end
        for (int w = 100; w < 108; w++) begin
            op(1'b0, w, 2'd0, 4'b1111, 32'd0, 3, 0, 1, "R8 read", rd);
            chk(rd == refm[w], "R6 shared low half", rd, refm[w]);
        end

        // R7: byte writes on every lane
        for (int w = 200; w < 216; w++) begin
            for (int ln = 0; ln < 4; ln++) begin
                logic [7:0] b;
                b = 8'(w * 7 + ln * 29);
                op(1'b1, w, 2'(ln), 4'(1 << ln), {4{b}}, 5, 1, 1, "R7 byte", rd);
                refm[w][ln*8 +: 8] = b;
                op(1'b0, w, 2'd0, 4'b1111, 32'd0, 3, 0, 1, "R8 read", rd);
                chk(rd == refm[w], "R7 merged word", rd, refm[w]);
            end
        end
        op(1'b1, 300, 2'd2, 4'b1100, 32'h1234_0000, 2, 1, 0, "R7 commit", rd);
        refm[300] = {16'h1234, refbuf};
        op(1'b0, 300, 2'd0, 4'b1111, 32'd0, 3, 0, 1, "R8 read", rd);
        chk(rd == refm[300], "R7 buffer untouched", rd, refm[300]);

        // R2: engine busy
        engine_busy = 1'b1;
        op(1'b1, 5, 2'd0, 4'b0011, 32'h0000_7777, 1, 0, 0, "R2 low", rd);
        op(1'b1, 5, 2'd2, 4'b1100, 32'h9999_0000, 1, 0, 0, "R2 high", rd);
        op(1'b1, 5, 2'd1, 4'b0010, 32'h0000_AB00, 1, 0, 0, "R2 byte", rd);
        op(1'b0, 5, 2'd0, 4'b1111, 32'd0, 1, 0, 0, "R2 read", rd);
        chk(rd == 32'd0, "R2 read data zero", rd, 32'd0);
        engine_busy = 1'b0;
        op(1'b0, 5, 2'd0, 4'b1111, 32'd0, 3, 0, 1, "R8 read", rd);
        chk(rd == refm[5], "R2 word unchanged", rd, refm[5]);
        op(1'b1, 6, 2'd2, 4'b1100, 32'h4444_0000, 2, 1, 0, "R2 commit", rd);
        refm[6] = {16'h4444, refbuf};
        op(1'b0, 6, 2'd0, 4'b1111, 32'd0, 3, 0, 1, "R8 read", rd);
        chk(rd == refm[6], "R2 buffer unchanged", rd, refm[6]);

        // R9: request during running operation ignored
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = {9'd10, 2'd0}; bus_be = 4'b0001; bus_wdata = 32'h0000_00C7;
        @(negedge clk);
        bus_addr = {9'd20, 2'd2}; bus_be = 4'b1100; bus_wdata = 32'hF00D_0000;
        @(negedge clk);
        bus_req = 1'b0;
        while (!bus_done) @(negedge clk);
        refm[10][7:0] = 8'hC7;
        op(1'b0, 20, 2'd0, 4'b1111, 32'd0, 3, 0, 1, "R8 read", rd);
        chk(rd == refm[20], "R9 overlapping request ignored", rd, refm[20]);
        op(1'b0, 10, 2'd0, 4'b1111, 32'd0, 3, 0, 1, "R8 read", rd);
        chk(rd == refm[10], "R9 first op completed", rd, refm[10]);

        summary();
    end
endmodule